// File: doc/BRIEF.md
# Write-Through Four-Way L1 Data Cache

This block is a physically addressed data cache that sits between a load/store pipeline and the next level of the memory hierarchy. It holds 32-byte lines in a 4-way, 128-set array and serves 64-bit requests that are aligned to a doubleword. Address bits 4:3 select the doubleword within a line. On a read hit the doubleword comes back one cycle after the request is accepted. On a write hit the new doubleword is merged into the stored line and is also sent to the next level.

A miss stalls the request port. The cache then asks the next level for the whole line that contains the address. When the 256-bit line arrives, it goes into a free way, or into the way that the tree pseudo-LRU selects if no way is free. A read miss then returns its doubleword. A write miss merges its data into the new line and then sends the write onward. Every write reaches the next level, whether it hits or misses, so the cache never holds data that the next level lacks.

The geometry, the address width and the word width are parameters. The tag width and the field positions are derived from them.

Top module: `wt_l1_cache`

## Requirements
- R1: After reset every line is invalid: `req_ready` is 1, `rsp_valid`, `wt_valid` and `fill_req_valid` are 0, and the first access to any address misses.
- R2: With the default geometry the set index is address bits 11:5 and the tag is bits 35:12. A hit needs a valid line in the indexed set whose stored tag equals the tag bits. Two addresses that differ only in tag bits never hit the same line.
- R3: A read hit raises `rsp_valid` in the cycle after acceptance. `rsp_rdata` is the line's bits [64*k+63 : 64*k], where k = address bits 4:3.
- R4: A write hit replaces only the doubleword selected by address bits 4:3. Later reads of the other three doublewords of that line return their earlier values.
- R5: Every accepted write, hit or miss, produces exactly one `wt_valid` pulse that carries the request's address and data. On a hit the pulse comes in the cycle after acceptance.
- R6: On a miss `req_ready` falls and `fill_req_valid` rises in the cycle after acceptance. `fill_req_addr` is the request address with bits 4:0 cleared. Both stay until the cycle in which `fill_rsp_valid` is seen.
- R7: A fill line holds the doubleword at line address +8k in bits [64*k+63 : 64*k], so +24 is most significant. The fill sets the line valid with the request's tag. The read response or write-through pulse follows in the next cycle. On a write miss the write data is merged after the fill.
- R8: A fill goes to the lowest-numbered invalid way of the set. Four distinct tags in one set therefore all stay resident.
- R9: When all four ways are valid, the victim follows a 3-bit tree per set. The root bit chooses between the pair {0,1} (0) and the pair {2,3} (1), and one bit per pair chooses the lower (0) or higher (1) way. Every hit and every fill points the bits away from the way it used. After ways 0,1,2,3 are filled in that order and way 0 is then hit, the next miss evicts way 2.
- R10: Sets are independent. A fill into one set does not change the hit or miss outcome in any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request (idle) |
| req_addr | input | ADDR_W | Physical byte address, doubleword aligned |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | WORD_W | Read data |
| fill_req_valid | output | 1 | Line fill requested (held until the response) |
| fill_req_addr | output | ADDR_W | Line-aligned address of the missing line |
| fill_rsp_valid | input | 1 | Fill line delivered this cycle |
| fill_rsp_line | input | LINE_BYTES*8 | Fill line, lowest address in the least significant bits |
| wt_valid | output | 1 | Write-through pulse to the next level |
| wt_addr | output | ADDR_W | Write-through address |
| wt_data | output | WORD_W | Write-through data |

## Verification
The bench builds the cache with a 14-bit address and 4 sets, and keeps the 32-byte line, the 64-bit word and the 4 ways. That leaves a 7-bit tag and a 2048-doubleword next-level memory that the bench can model in full. Every set, every way and every doubleword position can then be covered by short nested sweeps. The small set count also makes it cheap to reach a set that is completely full from a fresh reset, so the invalid-first placement and the exact pseudo-LRU eviction order can be predicted by hand and checked by which addresses miss afterwards.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_MISS = 1'b1
   } wtc_state_e;

   // tree layout: [2] root (0: pair 0/1, 1: pair 2/3), [1] pair 0/1, [0] pair 2/3
   function automatic logic [1:0] plru4_victim(input logic [2:0] t);
      logic [1:0] v;
      if (!t[2]) v = {1'b0, t[1]};
      else       v = {1'b1, t[0]};
      return v;
   endfunction

   function automatic logic [2:0] plru4_touch(input logic [2:0] t, input logic [1:0] w);
      logic [2:0] n;
      n = t;
      n[2] = ~w[1];
      if (!w[1]) n[1] = ~w[0];
      else       n[0] = ~w[0];
      return n;
   endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int SETS  = 128,
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             wr_en,
   input  logic [WAYS-1:0]  wr_way_oh,
   output logic [WAYS-1:0]  hit_oh,
   output logic [WAYS-1:0]  valid_row
);

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_way
         logic [SETS-1:0]  vld;
         logic [TAG_W-1:0] tg [SETS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               vld <= '0;
            else if (wr_en && wr_way_oh[w])
               vld[idx] <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (wr_en && wr_way_oh[w])
               tg[idx] <= lk_tag;
         end

         assign valid_row[w] = vld[idx];
         assign hit_oh[w]    = vld[idx] && (tg[idx] == lk_tag);
      end
   endgenerate

endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
   parameter int SETS   = 128,
   parameter int WAYS   = 4,
   parameter int LINE_W = 256,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WAYS-1:0]   rd_way_oh,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [WAYS-1:0]   wr_way_oh,
   input  logic [LINE_W-1:0] wr_line
);

   logic [LINE_W-1:0] way_line [WAYS];

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_way
         logic [LINE_W-1:0] mem [SETS];

         always_ff @(posedge clk) begin
            if (wr_en && wr_way_oh[w])
               mem[idx] <= wr_line;
         end

         assign way_line[w] = mem[idx];
      end
   endgenerate

   always_comb begin
      rd_line = '0;
      for (int i = 0; i < WAYS; i++)
         if (rd_way_oh[i]) rd_line |= way_line[i];
   end

endmodule

// File: rtl/wtc_repl.sv
module wtc_repl #(
   parameter int SETS  = 128,
   parameter int WAYS  = 4,
   parameter int IDX_W = 7,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  valid_row,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAYS-1:0]  victim_oh
);

   logic [WAY_W-1:0] tree_way;

   generate
      if (WAYS == 4) begin : g_tree4
         logic [2:0] bits [SETS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) bits[s] <= 3'b000;
            end else if (touch_en) begin
               bits[idx] <= wtc_pkg::plru4_touch(bits[idx], touch_way);
            end
         end

         assign tree_way = wtc_pkg::plru4_victim(bits[idx]);
      end else if (WAYS == 2) begin : g_tree2
         logic [SETS-1:0] bits;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bits <= '0;
            else if (touch_en)
               bits[idx] <= ~touch_way[0];
         end

         assign tree_way = bits[idx];
      end else begin : g_bad
         $error("wtc_repl: WAYS must be 2 or 4");
      end
   endgenerate

   always_comb begin
      logic found;
      found     = 1'b0;
      victim_oh = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (!valid_row[i] && !found) begin
            victim_oh[i] = 1'b1;
            found        = 1'b1;
         end
      end
      if (!found) victim_oh[tree_way] = 1'b1;
   end

endmodule

// File: rtl/wt_l1_cache.sv
module wt_l1_cache #(
   parameter int ADDR_W     = 36,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 4,
   parameter int WORD_W     = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    req_we,
   input  logic [WORD_W-1:0]       req_wdata,
   output logic                    rsp_valid,
   output logic [WORD_W-1:0]       rsp_rdata,
   output logic                    fill_req_valid,
   output logic [ADDR_W-1:0]       fill_req_addr,
   input  logic                    fill_rsp_valid,
   input  logic [LINE_BYTES*8-1:0] fill_rsp_line,
   output logic                    wt_valid,
   output logic [ADDR_W-1:0]       wt_addr,
   output logic [WORD_W-1:0]       wt_data
);
   import wtc_pkg::*;

   localparam int LINE_W  = LINE_BYTES * 8;
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int IDX_W   = $clog2(SETS);
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
   localparam int WBYTES  = WORD_W / 8;
   localparam int BSH     = $clog2(WBYTES);
   localparam int WORDS   = LINE_W / WORD_W;
   localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int WAY_W   = $clog2(WAYS);

   generate
      if ((1 << IDX_W) != SETS)       begin : g_chk_sets  $error("SETS must be a power of two"); end
      if ((1 << OFF_W) != LINE_BYTES) begin : g_chk_line  $error("LINE_BYTES must be a power of two"); end
      if (WORDS < 2 || (WORDS * WORD_W) != LINE_W)
                                      begin : g_chk_word  $error("line must hold several whole words"); end
      if (TAG_W < 1)                  begin : g_chk_tag   $error("address too narrow for geometry"); end
   endgenerate

   wtc_state_e        state;
   logic [ADDR_W-1:0] pend_addr;
   logic              pend_we;
   logic [WORD_W-1:0] pend_wdata;

   logic              accept, fill_done, hit_any, cur_we;
   logic [ADDR_W-1:0] lk_addr;
   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;
   logic [WSEL_W-1:0] wsel;
   logic [WORD_W-1:0] cur_wdata, sel_word;
   logic [WAYS-1:0]   hit_oh, valid_row, victim_oh, dw_oh;
   logic [WAY_W-1:0]  hit_way, victim_way, touch_way;
   logic [LINE_W-1:0] rd_line, src_line, merged_line, dw_line;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign fill_done = (state == ST_MISS) && fill_rsp_valid;

   assign lk_addr   = (state == ST_IDLE) ? req_addr  : pend_addr;
   assign cur_we    = (state == ST_IDLE) ? req_we    : pend_we;
   assign cur_wdata = (state == ST_IDLE) ? req_wdata : pend_wdata;
   assign lk_idx    = lk_addr[OFF_W +: IDX_W];
   assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
   assign wsel      = lk_addr[BSH +: WSEL_W];
   assign hit_any   = |hit_oh;

   wtc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (lk_idx),
      .lk_tag    (lk_tag),
      .wr_en     (fill_done),
      .wr_way_oh (victim_oh),
      .hit_oh    (hit_oh),
      .valid_row (valid_row)
   );

   wtc_repl #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (lk_idx),
      .valid_row (valid_row),
      .touch_en  ((accept && hit_any) || fill_done),
      .touch_way (touch_way),
      .victim_oh (victim_oh)
   );

   always_comb begin
      hit_way    = '0;
      victim_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_oh[i])    hit_way    = WAY_W'(i);
         if (victim_oh[i]) victim_way = WAY_W'(i);
      end
   end
   assign touch_way = fill_done ? victim_way : hit_way;

   // line source: stored line on a hit, incoming line on a fill
   assign src_line = (state == ST_IDLE) ? rd_line : fill_rsp_line;
   assign sel_word = src_line[wsel*WORD_W +: WORD_W];

   always_comb begin
      merged_line = src_line;
      merged_line[wsel*WORD_W +: WORD_W] = cur_wdata;
   end

   assign dw_oh   = fill_done ? victim_oh : hit_oh;
   assign dw_line = cur_we ? merged_line : fill_rsp_line;

   wtc_line_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_lines (
      .clk       (clk),
      .idx       (lk_idx),
      .rd_way_oh (hit_oh),
      .rd_line   (rd_line),
      .wr_en     ((accept && hit_any && req_we) || fill_done),
      .wr_way_oh (dw_oh),
      .wr_line   (dw_line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         pend_addr  <= '0;
         pend_we    <= 1'b0;
         pend_wdata <= '0;
      end else begin
         if (accept) begin
            pend_addr  <= req_addr;
            pend_we    <= req_we;
            pend_wdata <= req_wdata;
            if (!hit_any) state <= ST_MISS;
         end else if (fill_done) begin
            state <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         wt_valid  <= 1'b0;
         wt_addr   <= '0;
         wt_data   <= '0;
      end else begin
         rsp_valid <= ((accept && hit_any) || fill_done) && !cur_we;
         wt_valid  <= ((accept && hit_any) || fill_done) && cur_we;
         if ((accept && hit_any) || fill_done) begin
            rsp_rdata <= sel_word;
            wt_addr   <= lk_addr;
            wt_data   <= cur_wdata;
         end
      end
   end

   assign fill_req_valid = (state == ST_MISS);
   assign fill_req_addr  = {pend_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
   parameter int ADDR_W = 36,
   parameter int OFF_W  = 5,
   parameter int WAYS   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_we,
   input logic              hit_any,
   input logic              fill_req_valid,
   input logic [ADDR_W-1:0] fill_req_addr,
   input logic              fill_rsp_valid,
   input logic              rsp_valid,
   input logic              wt_valid,
   input logic [WAYS-1:0]   victim_oh
);

   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> !req_ready); // R6

   AST_FILL_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> (fill_req_addr[OFF_W-1:0] == '0)); // R6

   AST_MISS_REQUESTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !hit_any) |=> fill_req_valid); // R6

   AST_READ_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit_any && !req_we) |=> (rsp_valid && !wt_valid && !fill_req_valid)); // R3

   AST_WRITE_HIT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit_any && req_we) |=> (wt_valid && !rsp_valid)); // R5

   AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && fill_rsp_valid) |=> ((rsp_valid != wt_valid) && !fill_req_valid)); // R7

   AST_NO_OUTPUT_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> (!rsp_valid && !wt_valid)); // R6

   AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> ($countones(victim_oh) == 1)); // R8

endmodule

bind wt_l1_cache wtc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_we         (req_we),
   .hit_any        (hit_any),
   .fill_req_valid (fill_req_valid),
   .fill_req_addr  (fill_req_addr),
   .fill_rsp_valid (fill_rsp_valid),
   .rsp_valid      (rsp_valid),
   .wt_valid       (wt_valid),
   .victim_oh      (victim_oh)
);

// File: tb/wt_l1_cache_tb.sv
module wt_l1_cache_tb;
   localparam int AW = 14;
   localparam int NSETS = 4;
   localparam int NDW = 1 << (AW - 3);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [AW-1:0]  req_addr = '0;
   logic           req_we = 1'b0;
   logic [63:0]    req_wdata = '0;
   logic           rsp_valid;
   logic [63:0]    rsp_rdata;
   logic           fill_req_valid;
   logic [AW-1:0]  fill_req_addr;
   logic           fill_rsp_valid = 1'b0;
   logic [255:0]   fill_rsp_line = '0;
   logic           wt_valid;
   logic [AW-1:0]  wt_addr;
   logic [63:0]    wt_data;

   always #4 clk = ~clk;

   wt_l1_cache #(.ADDR_W(AW), .SETS(NSETS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_we(req_we), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
      .fill_rsp_valid(fill_rsp_valid), .fill_rsp_line(fill_rsp_line),
      .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
   );

   int n_chk = 0;
   int n_err = 0;
   int fill_cnt = 0;
   logic [63:0] exp_mem [NDW];
   logic [63:0] nl_mem  [NDW];

   function automatic logic [63:0] seed_word(input int i);
      return {32'hC0DE0000 + 32'(i), 32'(i) * 32'h01000193};
   endfunction

   function automatic logic [AW-1:0] mk(input int tag, input int set, input int wd);
      return {7'(tag), 2'(set), 2'(wd), 3'b000};
   endfunction

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", what, act, expv);
      end
   endtask

   // next level: answers line requests from its own memory two cycles later
   initial begin
      forever begin
         @(negedge clk);
         if (fill_req_valid && rst_n) begin
            logic [AW-1:0] la;
            int b;
            la = fill_req_addr;
            fill_cnt++;
            check("R6 fill address line aligned", 64'(la[4:0]), 64'd0);
            b = int'(la >> 3);
            repeat (2) @(negedge clk);
            fill_rsp_line  = {nl_mem[b+3], nl_mem[b+2], nl_mem[b+1], nl_mem[b]};
            fill_rsp_valid = 1'b1;
            @(negedge clk);
            fill_rsp_valid = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && wt_valid) nl_mem[int'(wt_addr >> 3)] = wt_data;
   end

   logic [63:0]   last_rd;
   logic          last_miss;
   logic          last_stall;
   logic          last_wt;
   logic [AW-1:0] last_wt_a;
   logic [63:0]   last_wt_d;

   task automatic access(input logic [AW-1:0] a, input logic we, input logic [63:0] wd);
      int f0;
      int t;
      f0 = fill_cnt;
      last_stall = 1'b0;
      last_wt = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!(we ? wt_valid : rsp_valid) && t < 50) begin
         if (!req_ready) last_stall = 1'b1;
         @(negedge clk);
         t++;
      end
      if (t >= 50) begin
         n_chk++; n_err++;
         $display("FAIL R5 no completion for addr %h actual=none expected=pulse", a);
      end
      last_rd   = rsp_rdata;
      last_wt   = wt_valid;
      last_wt_a = wt_addr;
      last_wt_d = wt_data;
      last_miss = (fill_cnt != f0);
      if (we) exp_mem[int'(a >> 3)] = wd;
   endtask

   task automatic rd_expect(input string what, input int tag, input int set, input int wd, input logic miss);
      logic [AW-1:0] a;
      a = mk(tag, set, wd);
      access(a, 1'b0, 64'd0);
      check({what, " data"}, last_rd, exp_mem[int'(a >> 3)]);
      check({what, " miss"}, 64'(last_miss), 64'(miss));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NDW; i++) begin
         exp_mem[i] = seed_word(i);
         nl_mem[i]  = seed_word(i);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 ready after reset", 64'(req_ready), 64'd1);
      check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      check("R1 wt_valid after reset", 64'(wt_valid), 64'd0);
      check("R1 fill_req_valid after reset", 64'(fill_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R7 R8: first touches miss, four tags per set fill the free ways
      for (int s = 0; s < NSETS; s++)
         for (int tg = 0; tg < 4; tg++) begin
            rd_expect("R1 R7 first read", tg, s, (tg + s) % 4, 1'b1);
            check("R6 stall during miss", 64'(last_stall), 64'd1);
         end

      // R2 R3 R8: every word of every resident line hits
      for (int s = 0; s < NSETS; s++)
         for (int tg = 0; tg < 4; tg++)
            for (int wd = 0; wd < 4; wd++)
               rd_expect("R2 R3 R8 resident read", tg, s, wd, 1'b0);

      // R4 R5: write hits merge one word and go through
      for (int s = 0; s < NSETS; s++) begin
         logic [AW-1:0] a;
         logic [63:0] v;
         a = mk(1, s, s);
         v = 64'hFEED_0000_0000_0000 | 64'(s * 17 + 3);
         access(a, 1'b1, v);
         check("R5 write-through pulse", 64'(last_wt), 64'd1);
         check("R5 write-through addr", 64'(last_wt_a), 64'(a));
         check("R5 write-through data", last_wt_d, v);
         check("R4 write hit no fill", 64'(last_miss), 64'd0);
         for (int wd = 0; wd < 4; wd++)
            rd_expect("R4 line after write hit", 1, s, wd, 1'b0);
      end

      // R9: eviction order in one full set
      do_reset();
      for (int tg = 10; tg < 14; tg++) rd_expect("R9 fill ways", tg, 2, 0, 1'b1);
      rd_expect("R9 touch way 0", 10, 2, 1, 1'b0);
      rd_expect("R9 new tag misses", 14, 2, 3, 1'b1);
      rd_expect("R9 way 0 kept", 10, 2, 2, 1'b0);
      rd_expect("R9 way 1 kept", 11, 2, 0, 1'b0);
      rd_expect("R9 way 3 kept", 13, 2, 0, 1'b0);
      rd_expect("R9 way 2 evicted", 12, 2, 0, 1'b1);

      // R10 R2: same tag in other sets is separate
      rd_expect("R10 set 0 miss", 3, 0, 0, 1'b1);
      rd_expect("R10 set 1 same tag miss", 3, 1, 0, 1'b1);
      rd_expect("R10 set 0 still hits", 3, 0, 1, 1'b0);
      rd_expect("R2 tag differs misses", 35, 0, 1, 1'b1);

      // R7: write miss fills then merges
      begin
         logic [AW-1:0] a;
         a = mk(20, 3, 2);
         access(a, 1'b1, 64'h0123_4567_89AB_CDEF);
         check("R7 write miss fills", 64'(last_miss), 64'd1);
         check("R6 write miss stalls", 64'(last_stall), 64'd1);
         check("R5 write miss through addr", 64'(last_wt_a), 64'(a));
         check("R5 write miss through data", last_wt_d, 64'h0123_4567_89AB_CDEF);
         for (int wd = 0; wd < 4; wd++)
            rd_expect("R7 line after write miss", 20, 3, wd, 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule